// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up pause. It then runs a fixed number of wake-up cycles, each with a RAS pulse. From then on it issues CAS-before-RAS refresh cycles at a programmable interval. These cycles carry no address, because the memory's own row counter picks the row. Both byte strobes are always driven together. On a level request the block can also park the memory in self-refresh, and it brings it back out again.

The block shares the memory strobes with an access controller through a request/grant pair. It raises `ref_req` and starts a cycle only in a clock where the controller answers with `ref_grant`. While it owns the strobes, `busy` is high and `ready` is low. A refresh that cannot run because the grant is withheld is not lost. A pending counter holds it, and owed refreshes run back to back once the grant returns. If the backlog reaches its ceiling, the refresh interval counts as exceeded, and the next granted slot repeats the whole wake-up series. All time limits are parameters in clock cycles.

Top module: `drs_refresh_seq`

## Requirements
- R1: While reset is applied, `ras_n`, `lcas_n` and `ucas_n` are high, `ready` and `ref_req` are low, and `busy` is high.
- R2: No RAS pulse starts earlier than `T_PWR` cycles after reset is released. `ready` stays low until exactly `WAKE_N` RAS pulses have completed.
- R3: Every cycle is CAS-before-RAS. CAS is low for at least `T_CSR` cycles before RAS falls, and `lcas_n` always equals `ucas_n`.
- R4: CAS stays low for at least `T_CHR` cycles after RAS falls. RAS stays low for at least `T_RAS` cycles. RAS stays high for at least `T_RP` cycles before it falls again.
- R5: With the grant always given, one refresh is issued per `T_REFI` cycles on average.
- R6: RAS falls only while `busy` is high. RAS and CAS are never low while `ready` is high. With the grant withheld, no new cycle starts.
- R7: Refreshes owed while the grant was withheld (fewer than `PEND_MAX`) are all issued once the grant returns, without a new wake-up series.
- R8: If the backlog reaches `PEND_MAX`, the next granted slot runs `WAKE_N` RAS pulses, and `ready` is low throughout.
- R9: While `sr_req` is high, after a grant, the block performs a CAS-before-RAS entry. It then holds RAS and CAS low for as long as `sr_req` stays high, well beyond `T_RAS`, with `ready` low.
- R10: After `sr_req` falls, RAS goes high, and `ready` returns only after RAS has been high for at least `T_RP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request to stay in self-refresh |
| ref_grant | input | 1 | Access controller has released the strobes |
| ref_req | output | 1 | Sequencer wants the strobes |
| busy | output | 1 | Sequencer owns the strobes; accesses are blocked |
| ready | output | 1 | Memory is available for normal accesses |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |

## Verification
The refresh engine is tried under four grant patterns, and each one separates a different failure. With the grant held steady, the test measures the refresh rate. With a short withholding, it shows that owed refreshes are replayed without a wake-up series. With a long withholding, it forces the overrun path, which must produce a full wake-up series. With a random grant and random self-refresh requests, it stresses the handshake against the strobe ordering and pulse widths, which a monitor measures on every cycle. A directed self-refresh episode separates a normal refresh from a held entry. It also checks that the exit precharge time runs before `ready` returns.

// File: rtl/drs_pkg.sv
`timescale 1ns/1ps
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PWR, ST_WAKE, ST_IDLE, ST_REQ, ST_REF, ST_SR
  } seq_st_t;

  typedef enum logic [1:0] {
    EG_IDLE, EG_SETUP, EG_LOW, EG_PRE
  } eng_st_t;
endpackage

// File: rtl/drs_refi_timer.sv
`timescale 1ns/1ps
module drs_refi_timer #(
  parameter int unsigned T_REFI   = 780,
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  output logic pend_any,
  output logic overrun
);
  localparam int TW = $clog2(T_REFI + 1);
  localparam int NW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [NW-1:0] pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = 1'b0;
    tcnt_d = tcnt_q + 1'b1;
    if (tcnt_q == TW'(T_REFI - 1)) begin
      tcnt_d = '0;
      tick   = 1'b1;
    end
    pend_d = pend_q;
    if (tick && !take) begin
      if (pend_q != NW'(PEND_MAX)) pend_d = pend_q + 1'b1;
    end else if (!tick && take) begin
      if (pend_q != '0) pend_d = pend_q - 1'b1;
    end
    if (clr) begin
      tcnt_d = '0;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_any = (pend_q != '0);
  assign overrun  = (pend_q == NW'(PEND_MAX));

  // R7
  pend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_q) <= int'(PEND_MAX));

  // R7
  take_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_any);
endmodule

// File: rtl/drs_cbr_engine.sv
`timescale 1ns/1ps
module drs_cbr_engine
  import drs_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_CHR = 1,
  parameter int unsigned T_RAS = 3,
  parameter int unsigned T_RP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done
);
  localparam int unsigned M1 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned MX = (M1 > T_RP) ? M1 : T_RP;
  localparam int CW = $clog2(MX + 1);

  eng_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lo_cnt;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      EG_IDLE: if (start) begin
        st_d  = EG_SETUP;
        cnt_d = '0;
      end
      EG_SETUP: if (cnt_q == CW'(T_CSR - 1)) begin
        st_d  = EG_LOW;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      EG_LOW: if (cnt_q == CW'(T_RAS - 1)) begin
        if (!hold) begin
          st_d  = EG_PRE;
          cnt_d = '0;
        end
      end else cnt_d = cnt_q + 1'b1;
      EG_PRE: if (cnt_q == CW'(T_RP - 1)) begin
        st_d  = EG_IDLE;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      default: st_d = EG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle  = (st_q == EG_IDLE);
  assign done  = (st_q == EG_PRE) && (cnt_q == CW'(T_RP - 1));
  assign ras_n = (st_q != EG_LOW);
  assign cas_n = !((st_q == EG_SETUP) ||
                   ((st_q == EG_LOW) && ((cnt_q < CW'(T_CHR)) || hold)));

  // checker counter: cycles RAS has been low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (ras_n) lo_cnt <= '0;
    else if (lo_cnt != CW'(T_RAS)) lo_cnt <= lo_cnt + 1'b1;
  end

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (int'(lo_cnt) >= int'(T_RAS)));
endmodule

// File: rtl/drs_refresh_seq.sv
`timescale 1ns/1ps
module drs_refresh_seq
  import drs_pkg::*;
#(
  parameter int unsigned T_PWR    = 10000,
  parameter int unsigned WAKE_N   = 8,
  parameter int unsigned T_REFI   = 780,
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned T_CSR    = 1,
  parameter int unsigned T_CHR    = 1,
  parameter int unsigned T_RAS    = 3,
  parameter int unsigned T_RP     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic ref_grant,
  output logic ref_req,
  output logic busy,
  output logic ready,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n
);
  localparam int PW = $clog2(T_PWR + 1);
  localparam int WW = $clog2(WAKE_N + 1);

  seq_st_t       st_q, st_d;
  logic [PW-1:0] pwr_q, pwr_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          eng_start, eng_hold, eng_idle, eng_done, eng_cas_n;
  logic          pend_any, overrun, tmr_clr, tmr_take, want;

  assign want = pend_any || sr_req;

  always_comb begin
    st_d   = st_q;
    pwr_d  = pwr_q;
    wake_d = wake_q;
    case (st_q)
      ST_PWR: if (pwr_q == PW'(T_PWR - 1)) begin
        st_d   = ST_WAKE;
        wake_d = '0;
      end else pwr_d = pwr_q + 1'b1;
      ST_WAKE: if (eng_done) begin
        if (wake_q == WW'(WAKE_N - 1)) st_d = ST_IDLE;
        else wake_d = wake_q + 1'b1;
      end
      ST_IDLE: if (want) st_d = ST_REQ;
      ST_REQ: begin
        if (!want) st_d = ST_IDLE;
        else if (ref_grant) begin
          if (overrun) begin
            st_d   = ST_WAKE;
            wake_d = '0;
          end else if (pend_any) st_d = ST_REF;
          else st_d = ST_SR;
        end
      end
      ST_REF: if (eng_done) st_d = ST_IDLE;
      ST_SR:  if (eng_done) st_d = ST_IDLE;
      default: st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      pwr_q  <= '0;
      wake_q <= '0;
    end else begin
      st_q   <= st_d;
      pwr_q  <= pwr_d;
      wake_q <= wake_d;
    end
  end

  assign eng_start = ((st_q == ST_REQ) && ref_grant && want) ||
                     ((st_q == ST_WAKE) && eng_idle);
  assign eng_hold  = (st_q == ST_SR) && sr_req;
  assign tmr_clr   = (st_q == ST_PWR) || (st_q == ST_WAKE) || (st_q == ST_SR);
  assign tmr_take  = (st_q == ST_REF) && eng_done;

  drs_refi_timer #(.T_REFI(T_REFI), .PEND_MAX(PEND_MAX)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .take(tmr_take),
    .pend_any(pend_any), .overrun(overrun)
  );

  drs_cbr_engine #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) i_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .hold(eng_hold),
    .ras_n(ras_n), .cas_n(eng_cas_n), .idle(eng_idle), .done(eng_done)
  );

  assign lcas_n  = eng_cas_n;
  assign ucas_n  = eng_cas_n;
  assign ready   = (st_q == ST_IDLE) || (st_q == ST_REQ);
  assign busy    = !ready;
  assign ref_req = (st_q == ST_REQ);

  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ras_n && lcas_n && ucas_n));

  // R6
  fall_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> busy);

  // R3
  byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcas_n == ucas_n);

  // R10
  exit_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ras_n));
endmodule

// File: tb/test_drs_refresh_seq.sv
`timescale 1ns/1ps
module test_drs_refresh_seq;
  localparam int T_PWR = 200, WAKE_N = 8, T_REFI = 100, PEND_MAX = 4;
  localparam int T_CSR = 2, T_CHR = 3, T_RAS = 6, T_RP = 4;

  logic clk, rst_n, sr_req, ref_grant;
  logic ref_req, busy, ready, ras_n, lcas_n, ucas_n;

  int checks = 0, errors = 0;
  int cyc = 0, falls = 0, first_fall = -1;
  int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 0, cas_after = 0;
  logic ras_prev = 1'b1, cas_prev = 1'b1, ready_low_seen = 1'b0;
  bit done_flag = 0;

  drs_refresh_seq #(.T_PWR(T_PWR), .WAKE_N(WAKE_N), .T_REFI(T_REFI),
    .PEND_MAX(PEND_MAX), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS),
    .T_RP(T_RP)) i_drs_refresh_seq (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .ref_grant(ref_grant),
    .ref_req(ref_req), .busy(busy), .ready(ready), .ras_n(ras_n),
    .lcas_n(lcas_n), .ucas_n(ucas_n));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @cyc %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_refreshes(input int window, input int interval);
    return window / interval;
  endfunction

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (lcas_n != ucas_n) check(0, "R3 byte strobes", int'(lcas_n), int'(ucas_n));
      if (ready && !ras_n) check(0, "R6 ras low while ready", 0, 1);
      if (!ready) ready_low_seen = 1'b1;
      if (ras_prev && !ras_n) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
        check(cas_lo_run >= T_CSR, "R3 cas setup", cas_lo_run, T_CSR);
        check(ras_hi_run >= T_RP, "R4 precharge", ras_hi_run, T_RP);
        check(busy, "R6 busy at fall", int'(busy), 1);
      end
      if (!ras_prev && ras_n)
        check(ras_lo_run >= T_RAS, "R4 ras width", ras_lo_run, T_RAS);
      if (!ras_n && !cas_prev && lcas_n)
        check(cas_after >= T_CHR, "R4 cas hold", cas_after, T_CHR);
      cas_lo_run = !lcas_n ? cas_lo_run + 1 : 0;
      ras_lo_run = !ras_n ? ras_lo_run + 1 : 0;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_after  = ras_n ? 0 : (!lcas_n ? cas_after + 1 : cas_after);
      ras_prev = ras_n;
      cas_prev = lcas_n;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int f0, t0, hi_at_ready;
    bit seen;
    void'($urandom(32'd1234));
    rst_n = 1'b0; sr_req = 1'b0; ref_grant = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(ras_n && lcas_n && ucas_n, "R1 strobes high", int'(ras_n), 1);
    check(!ready && !ref_req, "R1 ready/req low", int'(ready), 0);
    check(busy, "R1 busy high", int'(busy), 1);
    @(posedge clk); #2 rst_n = 1'b1;

    // R2: wake-up
    t0 = 0;
    while (!ready && t0 < 2000) begin @(negedge clk); t0++; end
    check(first_fall >= T_PWR, "R2 power pause", first_fall, T_PWR);
    check(falls == WAKE_N, "R2 wake count", falls, WAKE_N);

    // R5: steady grant
    f0 = falls;
    wait_cycles(1000);
    check((falls - f0) >= exp_refreshes(1000, T_REFI) - 1 &&
          (falls - f0) <= exp_refreshes(1000, T_REFI) + 1,
          "R5 refresh rate", falls - f0, exp_refreshes(1000, T_REFI));

    // R6/R7: short withholding
    @(posedge clk); #2 ref_grant = 1'b0;
    wait_cycles(20);
    f0 = falls;
    wait_cycles(230);
    check(falls == f0, "R6 no cycle without grant", falls - f0, 0);
    @(posedge clk); #2 ref_grant = 1'b1;
    f0 = falls;
    wait_cycles(80);
    check((falls - f0) >= 2 && (falls - f0) <= 4, "R7 owed refreshes", falls - f0, 3);
    check((falls - f0) < WAKE_N, "R7 no wake series", falls - f0, 3);

    // R8: overrun
    wait_cycles(60);
    @(posedge clk); #2 ref_grant = 1'b0;
    wait_cycles(450);
    ready_low_seen = 1'b0;
    f0 = falls;
    @(posedge clk); #2 ref_grant = 1'b1;
    wait_cycles(200);
    check((falls - f0) >= WAKE_N && (falls - f0) <= WAKE_N + 2,
          "R8 wake repeated", falls - f0, WAKE_N);
    check(ready_low_seen, "R8 ready dropped", int'(ready_low_seen), 1);

    // R9: self-refresh entry
    @(posedge clk); #2 sr_req = 1'b1;
    wait_cycles(100);
    check(!ras_n && !lcas_n, "R9 strobes held low", int'(ras_n), 0);
    check(!ready, "R9 ready low", int'(ready), 0);
    check(ras_lo_run > T_RAS * 4, "R9 held beyond tRAS", ras_lo_run, T_RAS * 4);

    // R10: exit
    @(posedge clk); #2 sr_req = 1'b0;
    seen = 0; hi_at_ready = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (ready && !seen) begin seen = 1; hi_at_ready = ras_hi_run; end
    end
    check(seen, "R10 ready returns", int'(seen), 1);
    check(hi_at_ready >= T_RP, "R10 exit precharge", hi_at_ready, T_RP);

    // random traffic
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #2;
      ref_grant = ($urandom % 4) != 0;
      if (!sr_req && ($urandom % 40) == 0) sr_req = 1'b1;
      else if (sr_req && ($urandom % 6) == 0) sr_req = 1'b0;
      wait_cycles(10);
    end
    @(posedge clk); #2 sr_req = 1'b0; ref_grant = 1'b1;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ready) seen = 1;
    end
    check(seen, "R6 ready after random phase", int'(seen), 1);
    finish_run();
  end
endmodule